// File: doc/BRIEF.md
# Station Address Filter and Message Gate

This block sits between a biphase frame deserializer and the software that reads received frames. For each frame it gets a data word, a 3-bit station address, a frame strobe and an error flag. It decides whether the frame enters an 8-entry receive queue. It applies address filtering once per message, on the first frame only. The deserializer tells the block when the message ends, and the block then returns to waiting for a new first frame.

There are three modes. In the open mode every frame is kept. In the short-address mode, the station address of the first frame is compared with the low three bits of a programmable node address. In the wide-address mode, the low byte of the first frame's data word is compared with all eight bits of the node address. The rules for reporting errors differ between frames. An error in a first frame is always reported. An error in a later frame is reported only if the message was accepted. A first frame that does not match and has no error aborts reception for the rest of the message.

The consumer sees the word at the queue head together with its station address, error bit, an end-of-message delimiter flag and a single-frame flag. It advances the queue with a pop strobe.

Top module: `stnFilterGate`

## Requirements
- R1: After reset, dataAvail, overrun and rxAbort are all 0.
- R2: With modeSel = 2'b00 (open mode), every frame is queued whatever its station address.
- R3: With modeSel = 2'b01, a first frame whose frmStation equals netAddr[2:0] is queued, and so is every later frame until msgEnd.
- R4: With modeSel = 2'b10 or 2'b11, the value compared with netAddr[7:0] is the first frame's frmWord[7:0]. frmStation plays no part in this compare.
- R5: A nonmatching first frame with frmErr = 0 is not queued. rxAbort is high for exactly the one cycle after that frame is sampled. No further frame is queued until msgEnd.
- R6: A nonmatching first frame with frmErr = 1 is queued with headErr = 1. Later frames of that message are not queued, even when they carry errors.
- R7: In an accepted message, a later frame with frmErr = 1 is queued with headErr = 1.
- R8: While dataAvail is 1, headWord, headStation and headErr show the oldest queued frame. A popReq cycle replaces them with the next entry.
- R9: headDelim is 1 exactly when dataAvail is 1 and headStation = 3'b111.
- R10: headSingle is 1 exactly when the head entry was the first frame of its message and bit 14 of its word is 0.
- R11: msgEnd makes the next frame a first frame again. A frame sampled in the same cycle as msgEnd is still handled under the current message.
- R12: The queue holds 8 entries. A frame pushed into a full queue with no pop in the same cycle is discarded, and overrun is set and stays set until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| modeSel | input | 2 | 00 open, 01 short address, 1x wide address |
| netAddr | input | 8 | Programmable node address |
| frmValid | input | 1 | One-cycle strobe: a received frame is present |
| frmWord | input | 16 | Received data word |
| frmStation | input | 3 | Received station address |
| frmErr | input | 1 | Frame was received with an error |
| msgEnd | input | 1 | End of the current message |
| popReq | input | 1 | Consumer removes the head entry |
| dataAvail | output | 1 | Queue holds at least one entry |
| headWord | output | 16 | Data word at the head |
| headStation | output | 3 | Station address at the head |
| headErr | output | 1 | Error bit at the head |
| headDelim | output | 1 | Head carries the end-of-message station address |
| headSingle | output | 1 | Head is a single-frame message start |
| rxAbort | output | 1 | Pulse: message rejected on its first frame |
| overrun | output | 1 | Sticky queue overflow |

## Verification
The hardest situation to reach is a message that is rejected but whose first frame still has to be reported. This needs a nonmatching first frame that carries an error, followed by later erroneous frames that must be silently dropped. The bench builds this case directly. It also covers a frame that arrives in the same cycle as msgEnd, followed at once by a new first frame. Overflow is reached by sending nine frames without popping.

// File: rtl/stnFilterPkg.sv
package stnFilterPkg;
  typedef enum logic [1:0] {StIdle = 2'd0, StPass = 2'd1, StDrop = 2'd2} stateT;

  typedef struct packed {
    logic push;
    logic first;
    logic abort;
  } strobeT;
endpackage

// File: rtl/stnCtrl.sv
module stnCtrl
  import stnFilterPkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic [1:0] modeSel,
  input  logic       frmValid,
  input  logic       frmErr,
  input  logic       msgEnd,
  input  logic       addrMatch,
  output strobeT     strb,
  output logic       rxAbort
);
  stateT state, stateNext;
  logic  accept;

  always_comb begin
    accept    = (modeSel == 2'b00) || addrMatch;
    strb      = '0;
    stateNext = state;
    if (frmValid) begin
      unique case (state)
        StIdle: begin
          strb.push  = accept || frmErr;
          strb.first = 1'b1;
          strb.abort = !accept && !frmErr;
          stateNext  = accept ? StPass : StDrop;
        end
        StPass: strb.push = 1'b1;
        default: ;
      endcase
    end
    if (msgEnd) stateNext = StIdle;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= StIdle;
      rxAbort <= 1'b0;
    end else begin
      state   <= stateNext;
      rxAbort <= strb.abort;
    end
  end
endmodule

// File: rtl/stnPath.sv
module stnPath
  import stnFilterPkg::*;
#(
  parameter int DATA_W  = 16,
  parameter int STN_W   = 3,
  parameter int NADDR_W = 8,
  parameter int DEPTH   = 8,
  parameter int CMD_BIT = 14
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [1:0]         modeSel,
  input  logic [NADDR_W-1:0] netAddr,
  input  logic [DATA_W-1:0]  frmWord,
  input  logic [STN_W-1:0]   frmStation,
  input  logic               frmErr,
  input  strobeT             strb,
  input  logic               popReq,
  output logic               addrMatch,
  output logic               dataAvail,
  output logic [DATA_W-1:0]  headWord,
  output logic [STN_W-1:0]   headStation,
  output logic               headErr,
  output logic               headDelim,
  output logic               headSingle,
  output logic               overrun
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);
  localparam logic [STN_W-1:0] DELIM_STN = '1;

  typedef struct packed {
    logic              first;
    logic              err;
    logic [STN_W-1:0]  stn;
    logic [DATA_W-1:0] word;
  } entryT;

  entryT             mem [DEPTH];
  logic [PTR_W-1:0]  wrPtr, rdPtr;
  logic [CNT_W-1:0]  count;
  logic              doPush, doPop, full;
  entryT             head;

  always_comb begin
    unique case (modeSel)
      2'b00:   addrMatch = 1'b0;
      2'b01:   addrMatch = (frmStation == netAddr[STN_W-1:0]);
      default: addrMatch = (frmWord[NADDR_W-1:0] == netAddr);
    endcase
  end

  assign full   = (count == CNT_W'(DEPTH));
  assign doPop  = popReq && (count != '0);
  assign doPush = strb.push && (!full || doPop);

  function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (doPush) mem[wrPtr] <= '{first: strb.first, err: frmErr, stn: frmStation, word: frmWord};
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrPtr   <= '0;
      rdPtr   <= '0;
      count   <= '0;
      overrun <= 1'b0;
    end else begin
      if (doPush) wrPtr <= bump(wrPtr);
      if (doPop)  rdPtr <= bump(rdPtr);
      count <= count + CNT_W'(doPush) - CNT_W'(doPop);
      if (strb.push && !doPush) overrun <= 1'b1;
    end
  end

  assign head        = mem[rdPtr];
  assign dataAvail   = (count != '0);
  assign headWord    = head.word;
  assign headStation = head.stn;
  assign headErr     = head.err;
  assign headDelim   = dataAvail && (head.stn == DELIM_STN);
  assign headSingle  = dataAvail && head.first && !head.word[CMD_BIT];
endmodule

// File: rtl/stnFilterGate.sv
module stnFilterGate
  import stnFilterPkg::*;
#(
  parameter int DATA_W  = 16,
  parameter int STN_W   = 3,
  parameter int NADDR_W = 8,
  parameter int DEPTH   = 8,
  parameter int CMD_BIT = 14
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [1:0]         modeSel,
  input  logic [NADDR_W-1:0] netAddr,
  input  logic               frmValid,
  input  logic [DATA_W-1:0]  frmWord,
  input  logic [STN_W-1:0]   frmStation,
  input  logic               frmErr,
  input  logic               msgEnd,
  input  logic               popReq,
  output logic               dataAvail,
  output logic [DATA_W-1:0]  headWord,
  output logic [STN_W-1:0]   headStation,
  output logic               headErr,
  output logic               headDelim,
  output logic               headSingle,
  output logic               rxAbort,
  output logic               overrun
);
  strobeT strb;
  logic   addrMatch;

  stnCtrl ctrl_i (
    .clk(clk), .rstN(rstN), .modeSel(modeSel), .frmValid(frmValid),
    .frmErr(frmErr), .msgEnd(msgEnd), .addrMatch(addrMatch),
    .strb(strb), .rxAbort(rxAbort)
  );

  stnPath #(
    .DATA_W(DATA_W), .STN_W(STN_W), .NADDR_W(NADDR_W),
    .DEPTH(DEPTH), .CMD_BIT(CMD_BIT)
  ) path_i (
    .clk(clk), .rstN(rstN), .modeSel(modeSel), .netAddr(netAddr),
    .frmWord(frmWord), .frmStation(frmStation), .frmErr(frmErr),
    .strb(strb), .popReq(popReq), .addrMatch(addrMatch),
    .dataAvail(dataAvail), .headWord(headWord), .headStation(headStation),
    .headErr(headErr), .headDelim(headDelim), .headSingle(headSingle),
    .overrun(overrun)
  );
endmodule

// File: rtl/stnFilterGate_chk.sv
module stnFilterGate_chk (
  input logic       clk,
  input logic       rstN,
  input logic [1:0] modeSel,
  input logic       frmValid,
  input logic       frmErr,
  input logic       popReq,
  input logic       dataAvail,
  input logic       rxAbort,
  input logic       overrun
);
  // R12
  overrun_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    $past(overrun) |-> overrun);

  // R5
  abort_cause_chk: assert property (@(posedge clk) disable iff (!rstN)
    rxAbort |-> $past(frmValid && !frmErr));

  // R2
  open_no_abort_chk: assert property (@(posedge clk) disable iff (!rstN)
    rxAbort |-> $past(modeSel) != 2'b00);

  // R8
  avail_drop_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(dataAvail) |-> $past(popReq));

  // R8
  avail_rise_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(dataAvail) |-> $past(frmValid));
endmodule

bind stnFilterGate stnFilterGate_chk chk_i (
  .clk(clk), .rstN(rstN), .modeSel(modeSel), .frmValid(frmValid),
  .frmErr(frmErr), .popReq(popReq), .dataAvail(dataAvail),
  .rxAbort(rxAbort), .overrun(overrun)
);

// File: tb/stnFilterGate_tb_top.sv
`timescale 1ns/1ps
module stnFilterGate_tb_top;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [1:0]  modeSel = 2'b00;
  logic [7:0]  netAddr = 8'h00;
  logic        frmValid = 1'b0;
  logic [15:0] frmWord = '0;
  logic [2:0]  frmStation = '0;
  logic        frmErr = 1'b0;
  logic        msgEnd = 1'b0;
  logic        popReq = 1'b0;
  logic        dataAvail, headErr, headDelim, headSingle, rxAbort, overrun;
  logic [15:0] headWord;
  logic [2:0]  headStation;
  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  stnFilterGate dut_i (
    .clk(clk), .rstN(rstN), .modeSel(modeSel), .netAddr(netAddr),
    .frmValid(frmValid), .frmWord(frmWord), .frmStation(frmStation),
    .frmErr(frmErr), .msgEnd(msgEnd), .popReq(popReq),
    .dataAvail(dataAvail), .headWord(headWord), .headStation(headStation),
    .headErr(headErr), .headDelim(headDelim), .headSingle(headSingle),
    .rxAbort(rxAbort), .overrun(overrun)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic sendFrame(input logic [15:0] w, input logic [2:0] s, input logic e, input logic last);
    frmValid = 1'b1; frmWord = w; frmStation = s; frmErr = e; msgEnd = last;
    @(negedge clk);
    frmValid = 1'b0; frmErr = 1'b0; msgEnd = 1'b0;
  endtask

  task automatic endMsg();
    msgEnd = 1'b1;
    @(negedge clk);
    msgEnd = 1'b0;
  endtask

  task automatic popChk(input string tag, input logic [15:0] w, input logic [2:0] s,
                        input logic e, input logic single);
    chk({tag, " avail"}, dataAvail, 1'b1);
    chk({tag, " word"}, headWord, w);
    chk({tag, " stn"}, headStation, s);
    chk({tag, " err"}, headErr, e);
    chk({tag, " R9 delim"}, headDelim, s == 3'b111);
    chk({tag, " R10 single"}, headSingle, single);
    popReq = 1'b1;
    @(negedge clk);
    popReq = 1'b0;
  endtask

  task automatic testReset();
    chk("R1 avail", dataAvail, 1'b0);
    chk("R1 overrun", overrun, 1'b0);
    chk("R1 abort", rxAbort, 1'b0);
  endtask

  task automatic testOpen();
    modeSel = 2'b00; netAddr = 8'h01;
    sendFrame(16'h4123, 3'd5, 1'b0, 1'b0);
    sendFrame(16'h0456, 3'd7, 1'b0, 1'b1);
    chk("R2 abort", rxAbort, 1'b0);
    popChk("R2 f0", 16'h4123, 3'd5, 1'b0, 1'b0);
    popChk("R2 f1 R8", 16'h0456, 3'd7, 1'b0, 1'b0);
    chk("R8 empty", dataAvail, 1'b0);
  endtask

  task automatic testShortMatch();
    modeSel = 2'b01; netAddr = 8'hA3;
    sendFrame(16'h0011, 3'd3, 1'b0, 1'b0);
    sendFrame(16'h4022, 3'd2, 1'b0, 1'b0);
    sendFrame(16'h0033, 3'd7, 1'b1, 1'b1);
    popChk("R3 f0", 16'h0011, 3'd3, 1'b0, 1'b1);
    popChk("R3 f1", 16'h4022, 3'd2, 1'b0, 1'b0);
    popChk("R7 f2", 16'h0033, 3'd7, 1'b1, 1'b0);
    chk("R3 empty", dataAvail, 1'b0);
  endtask

  task automatic testShortReject();
    modeSel = 2'b01; netAddr = 8'hA3;
    sendFrame(16'h0044, 3'd4, 1'b0, 1'b0);
    chk("R5 abort pulse", rxAbort, 1'b1);
    sendFrame(16'h0055, 3'd3, 1'b0, 1'b0);
    chk("R5 abort one cycle", rxAbort, 1'b0);
    chk("R5 nothing queued", dataAvail, 1'b0);
    endMsg();
    sendFrame(16'h0066, 3'd3, 1'b0, 1'b1);
    popChk("R11 new msg", 16'h0066, 3'd3, 1'b0, 1'b1);
  endtask

  task automatic testWide();
    modeSel = 2'b10; netAddr = 8'hA3;
    sendFrame(16'h40A3, 3'd0, 1'b0, 1'b1);
    popChk("R4 match", 16'h40A3, 3'd0, 1'b0, 1'b0);
    sendFrame(16'h40A4, 3'd3, 1'b0, 1'b0);
    chk("R4 stn ignored abort", rxAbort, 1'b1);
    chk("R4 stn ignored", dataAvail, 1'b0);
    endMsg();
    modeSel = 2'b11;
    sendFrame(16'h00A3, 3'd6, 1'b0, 1'b1);
    popChk("R4 alt mode", 16'h00A3, 3'd6, 1'b0, 1'b1);
  endtask

  task automatic testRejectErr();
    modeSel = 2'b01; netAddr = 8'h01;
    sendFrame(16'h4077, 3'd5, 1'b1, 1'b0);
    chk("R6 no abort", rxAbort, 1'b0);
    sendFrame(16'h0088, 3'd5, 1'b1, 1'b0);
    sendFrame(16'h0099, 3'd1, 1'b0, 1'b1);
    popChk("R6 first err", 16'h4077, 3'd5, 1'b1, 1'b0);
    chk("R6 later dropped", dataAvail, 1'b0);
  endtask

  task automatic testCoincident();
    modeSel = 2'b01; netAddr = 8'h02;
    sendFrame(16'h4101, 3'd2, 1'b0, 1'b0);
    sendFrame(16'h4102, 3'd7, 1'b0, 1'b1);
    sendFrame(16'h4103, 3'd2, 1'b0, 1'b0);
    sendFrame(16'h4104, 3'd5, 1'b0, 1'b1);
    popChk("R11 a", 16'h4101, 3'd2, 1'b0, 1'b0);
    popChk("R11 end frame kept", 16'h4102, 3'd7, 1'b0, 1'b0);
    popChk("R11 second msg", 16'h4103, 3'd2, 1'b0, 1'b0);
    popChk("R11 second msg tail", 16'h4104, 3'd5, 1'b0, 1'b0);
    sendFrame(16'h4105, 3'd6, 1'b0, 1'b0);
    chk("R11 fresh first frame abort", rxAbort, 1'b1);
    endMsg();
    chk("R11 fresh first frame dropped", dataAvail, 1'b0);
  endtask

  task automatic testOverrun();
    modeSel = 2'b00;
    for (int i = 0; i < 9; i++) sendFrame(16'h4200 + 16'(i), 3'(i), 1'b0, i == 8);
    chk("R12 overrun", overrun, 1'b1);
    for (int i = 0; i < 8; i++) popChk("R12 entry", 16'h4200 + 16'(i), 3'(i), 1'b0, 1'b0);
    chk("R12 ninth discarded", dataAvail, 1'b0);
    chk("R12 sticky", overrun, 1'b1);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    testReset();
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testOpen();
    testShortMatch();
    testShortReject();
    testWide();
    testRejectErr();
    testCoincident();
    testOverrun();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule